// File: doc/BRIEF.md
# Scaled 16x16 Multiply Operand Unit

This block forms a scaled product from the low halves of two 32-bit operands. It has an unsigned flavour and a signed flavour. A start strobe captures the two 16-bit slices and the flavour. One clock later the scaled product appears on a 32-bit output, and a substitute-valid flag is raised. The surrounding pipeline uses the flagged value as the source operand of the next instruction, in place of the source field that instruction carries. Once that one instruction has advanced, the flag drops.

The two flavours scale differently:

- **Unsigned:** the 32-bit product is shifted right by sixteen bit positions.
- **Signed:** the product is shifted right arithmetically by fourteen bit positions, with sign extension. Negative results therefore round toward minus infinity, not toward zero.

Operand slice width, result width, both shift amounts and the multiplier arrangement are parameters.

Top module: `smo_unit`

## Requirements
- R1: Only bits [15:0] of each operand feed the multiplier. Bits [31:16] have no effect on the result.
- R2: With `signed_i` = 0 at start, the result is the unsigned 32-bit product of the two slices shifted right by 16, zero-extended. For example, 0xFFFF times 0xFFFF gives 0x0000FFFE.
- R3: With `signed_i` = 1 at start, the result is the signed 32-bit product of the two slices shifted right arithmetically by 14 and sign-extended to 32 bits.
- R4: In signed mode, 0x0001 times 0xFFFF (1 times -1) gives 0xFFFFFFFF (-1), not 0.
- R5: In signed mode, 0x8000 times 0x8000 gives 0x00010000.
- R6: After a clock edge with `start_i` high, `subst_valid_o` is 1 and `result_o` holds the new scaled product.
- R7: After a clock edge with `advance_i` high and `start_i` low, `subst_valid_o` is 0, so the substitution covers exactly one following instruction.
- R8: When `start_i` and `advance_i` are high on the same edge, the start wins: `subst_valid_o` stays 1 and carries the new result.
- R9: Reset clears `subst_valid_o` and makes `result_o` 0. With `start_i` low, `result_o` keeps its value.
- R10: The flavour is captured at start. Changing `signed_i` or the operands while no start is given does not change `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and flavour this edge |
| signed_i | input | 1 | 1 selects signed scaling, 0 unsigned |
| opd_a_i | input | 32 | First operand, low 16 bits used |
| opd_b_i | input | 32 | Second operand, low 16 bits used |
| advance_i | input | 1 | The following instruction leaves this edge |
| result_o | output | 32 | Scaled product used as substitute source |
| subst_valid_o | output | 1 | Substitute source is pending |

## Verification
The assertions assume that `start_i`, `signed_i` and the operands are settled before each rising edge. They also assume that a start and an advance on the same edge mean that a new scaled multiply replaces the one being consumed.

The bench drives every input on the falling edge, so those assumptions hold. It mixes seeded random operands, random upper-half garbage and random advance strobes with directed extremes: minimum times minimum, the -1 case, the all-ones unsigned product, and zero.

// File: rtl/smo_pkg.sv
package smo_pkg;
   typedef enum logic {
      MODE_UNS = 1'b0,
      MODE_SGN = 1'b1
   } smo_mode_e;
endpackage

// File: rtl/smo_capture.sv
module smo_capture
   import smo_pkg::*;
#(
   parameter int OPW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            advance_i,
   input  logic            signed_i,
   input  logic [OPW-1:0]  a_i,
   input  logic [OPW-1:0]  b_i,
   output logic [OPW-1:0]  a_q,
   output logic [OPW-1:0]  b_q,
   output smo_mode_e       mode_q,
   output logic            valid_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         mode_q <= MODE_UNS;
      end else if (start_i) begin
         a_q    <= a_i;
         b_q    <= b_i;
         mode_q <= smo_mode_e'(signed_i);
      end
   end

   // start has priority over advance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         valid_q <= 1'b0;
      else if (start_i)   valid_q <= 1'b1;
      else if (advance_i) valid_q <= 1'b0;
   end
endmodule

// File: rtl/smo_product.sv
module smo_product
   import smo_pkg::*;
#(
   parameter int OPW    = 16,
   parameter bit SHARED = 1'b1
) (
   input  logic [OPW-1:0]            a_i,
   input  logic [OPW-1:0]            b_i,
   input  smo_mode_e                 mode_i,
   output logic signed [2*OPW+1:0]   prod_o
);
   localparam int PW = 2*OPW + 2;

   generate
      if (SHARED) begin : g_shared
         // one (OPW+1)-bit signed array serves both flavours
         logic ext_a, ext_b;
         logic signed [PW-1:0] xa, xb;
         always_comb begin
            ext_a = (mode_i == MODE_SGN) & a_i[OPW-1];
            ext_b = (mode_i == MODE_SGN) & b_i[OPW-1];
            xa = $signed({{(OPW+2){ext_a}}, a_i});
            xb = $signed({{(OPW+2){ext_b}}, b_i});
            prod_o = xa * xb;
         end
      end else begin : g_split
         logic [2*OPW-1:0]        pu;
         logic signed [2*OPW-1:0] ps;
         always_comb begin
            pu = {{OPW{1'b0}}, a_i} * {{OPW{1'b0}}, b_i};
            ps = $signed({{OPW{a_i[OPW-1]}}, a_i}) * $signed({{OPW{b_i[OPW-1]}}, b_i});
            if (mode_i == MODE_SGN) prod_o = $signed({{2{ps[2*OPW-1]}}, ps});
            else                    prod_o = $signed({2'b00, pu});
         end
      end
   endgenerate
endmodule

// File: rtl/smo_scale.sv
module smo_scale
   import smo_pkg::*;
#(
   parameter int OPW = 16,
   parameter int DW  = 32,
   parameter int USH = 16,
   parameter int SSH = 14
) (
   input  logic signed [2*OPW+1:0] prod_i,
   input  smo_mode_e               mode_i,
   output logic [DW-1:0]           res_o
);
   localparam int PW = 2*OPW + 2;

   logic signed [PW-1:0] sh;
   // unsigned products are non-negative here, so an arithmetic shift is exact for both
   always_comb begin
      if (mode_i == MODE_SGN) sh = prod_i >>> SSH;
      else                    sh = prod_i >>> USH;
   end

   generate
      if (PW >= DW) begin : g_trunc
         assign res_o = sh[DW-1:0];
         if (PW > DW) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^sh[PW-1:DW];
         end
      end else begin : g_extend
         assign res_o = {{(DW-PW){sh[PW-1]}}, sh};
      end
   endgenerate
endmodule

// File: rtl/smo_unit.sv
module smo_unit
   import smo_pkg::*;
#(
   parameter int OPW        = 16,
   parameter int DW         = 32,
   parameter int USH        = 16,
   parameter int SSH        = 14,
   parameter bit SHARED_MUL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          signed_i,
   input  logic [DW-1:0] opd_a_i,
   input  logic [DW-1:0] opd_b_i,
   input  logic          advance_i,
   output logic [DW-1:0] result_o,
   output logic          subst_valid_o
);
   localparam int PW = 2*OPW + 2;

   generate
      if (OPW < 2 || OPW >= DW) begin : g_bad_opw
         $error("smo_unit: OPW must be at least 2 and below DW");
      end
      if (USH >= 2*OPW || SSH >= 2*OPW) begin : g_bad_shift
         $error("smo_unit: shift amounts must be below the product width");
      end
   endgenerate

   logic unused_upper;
   assign unused_upper = ^{opd_a_i[DW-1:OPW], opd_b_i[DW-1:OPW]};

   logic [OPW-1:0]        a_q, b_q;
   smo_mode_e             mode_q;
   logic signed [PW-1:0]  prod;

   smo_capture #(.OPW(OPW)) u_cap (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .advance_i(advance_i),
      .signed_i(signed_i), .a_i(opd_a_i[OPW-1:0]), .b_i(opd_b_i[OPW-1:0]),
      .a_q(a_q), .b_q(b_q), .mode_q(mode_q), .valid_q(subst_valid_o)
   );

   smo_product #(.OPW(OPW), .SHARED(SHARED_MUL)) u_mul (
      .a_i(a_q), .b_i(b_q), .mode_i(mode_q), .prod_o(prod)
   );

   smo_scale #(.OPW(OPW), .DW(DW), .USH(USH), .SSH(SSH)) u_scl (
      .prod_i(prod), .mode_i(mode_q), .res_o(result_o)
   );
endmodule

// File: rtl/smo_unit_chk.sv
module smo_unit_chk #(
   parameter int OPW = 16,
   parameter int DW  = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          signed_i,
   input logic [DW-1:0] opd_a_i,
   input logic [DW-1:0] opd_b_i,
   input logic          advance_i,
   input logic [DW-1:0] result_o,
   input logic          subst_valid_o
);
   a_r6_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> subst_valid_o);

   a_r7_clear_on_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_i && !start_i) |=> !subst_valid_o);

   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(result_o));

   a_r2_unsigned_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !signed_i) |=> (result_o[DW-1:DW-OPW] == '0));

   a_r4_one_times_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && signed_i && opd_a_i[OPW-1:0] == OPW'(1) && opd_b_i[OPW-1:0] == '1)
      |=> (result_o == '1));

   a_r5_min_times_min: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && signed_i && opd_a_i[15:0] == 16'h8000 && opd_b_i[15:0] == 16'h8000)
      |=> (result_o == 32'h0001_0000));
endmodule

bind smo_unit smo_unit_chk #(.OPW(OPW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
   .opd_a_i(opd_a_i), .opd_b_i(opd_b_i), .advance_i(advance_i),
   .result_o(result_o), .subst_valid_o(subst_valid_o)
);

// File: tb/smo_unit_test.sv
module smo_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, signed_i = 1'b0, advance_i = 1'b0;
   logic [31:0] opd_a_i = '0, opd_b_i = '0;
   logic [31:0] result_o;
   logic        subst_valid_o;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smo_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .opd_a_i(opd_a_i), .opd_b_i(opd_b_i), .advance_i(advance_i),
      .result_o(result_o), .subst_valid_o(subst_valid_o)
   );

   function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic s);
      longint pa, pb, p;
      if (s) begin
         pa = longint'($signed(a[15:0]));
         pb = longint'($signed(b[15:0]));
         p  = pa * pb;
         return p[45:14];
      end else begin
         pa = longint'({16'h0, a[15:0]});
         pb = longint'({16'h0, b[15:0]});
         p  = pa * pb;
         return p[47:16];
      end
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one start (optionally with advance), sample after the capturing edge
   task automatic issue(logic [31:0] a, logic [31:0] b, logic s, logic adv);
      @(negedge clk);
      start_i = 1'b1; signed_i = s; opd_a_i = a; opd_b_i = b; advance_i = adv;
      @(negedge clk);
      start_i = 1'b0; advance_i = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_res;
      logic        exp_val;
      repeat (3) @(negedge clk);
      chk("R9 reset valid", {31'h0, subst_valid_o}, 32'h0);
      chk("R9 reset result", result_o, 32'h0);
      rst_n = 1'b1;

      issue(32'h0000_0001, 32'h0000_FFFF, 1'b1, 1'b0);
      chk("R4 1*-1", result_o, 32'hFFFF_FFFF);
      chk("R6 valid after start", {31'h0, subst_valid_o}, 32'h1);

      issue(32'h0000_8000, 32'h0000_8000, 1'b1, 1'b0);
      chk("R5 min*min", result_o, 32'h0001_0000);

      issue(32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0);
      chk("R2 max unsigned", result_o, 32'h0000_FFFE);

      issue(32'h0000_8000, 32'h0000_7FFF, 1'b1, 1'b0);
      chk("R3 min*max", result_o, model(32'h8000, 32'h7FFF, 1'b1));

      issue(32'hDEAD_0003, 32'hBEEF_FFFB, 1'b1, 1'b0);
      chk("R1 upper ignored", result_o, 32'hFFFF_FFFF);

      issue(32'h1234_0000, 32'hFFFF_1234, 1'b0, 1'b0);
      chk("R1 zero operand", result_o, 32'h0);

      // R10: toggle mode and operands without start
      issue(32'h0000_C000, 32'h0000_4000, 1'b1, 1'b0);
      exp_res = model(32'hC000, 32'h4000, 1'b1);
      @(negedge clk);
      signed_i = 1'b0; opd_a_i = 32'hFFFF_FFFF; opd_b_i = 32'h1111_2222;
      @(negedge clk);
      chk("R10 mode held", result_o, exp_res);
      chk("R9 valid held", {31'h0, subst_valid_o}, 32'h1);

      // R7: advance clears
      advance_i = 1'b1;
      @(negedge clk);
      advance_i = 1'b0;
      chk("R7 cleared", {31'h0, subst_valid_o}, 32'h0);
      chk("R9 result kept after advance", result_o, exp_res);

      // R8: start and advance together
      issue(32'h0000_0100, 32'h0000_0200, 1'b0, 1'b1);
      chk("R8 start wins valid", {31'h0, subst_valid_o}, 32'h1);
      chk("R8 start wins result", result_o, model(32'h100, 32'h200, 1'b0));

      // random mix
      exp_val = subst_valid_o;
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a, b;
         logic s, adv, st;
         a = $urandom(); b = $urandom();
         s = 1'($urandom()); adv = 1'($urandom()); st = ($urandom() % 3) != 0;
         @(negedge clk);
         start_i = st; signed_i = s; opd_a_i = a; opd_b_i = b; advance_i = adv;
         if (st) begin
            exp_res = model(a, b, s);
            exp_val = 1'b1;
         end else if (adv) begin
            exp_val = 1'b0;
         end
         @(negedge clk);
         start_i = 1'b0; advance_i = 1'b0;
         chk(s ? "R3 random result" : "R2 random result", result_o, exp_res);
         chk(adv && !st ? "R7 random valid" : "R6 random valid",
             {31'h0, subst_valid_o}, {31'h0, exp_val});
      end

      done = 1;
      summary();
      $finish;
   end
endmodule